// File: doc/BRIEF.md
# Edge-Triggered GPIO Bank Interrupt Unit

This block watches the 32 already-synchronised input pins of one GPIO bank and raises a single interrupt line for the bank when a selected edge appears on any pin that software has not masked. Each pin has a 2-bit trigger selector that picks rising, falling or both edges, or turns detection off for that pin. Detected edges are held in a pending-status register until software writes a one to the matching bit. Pins are masked and unmasked through two separate write ports, one that sets mask bits and one that clears them, so a driver never needs a read-modify-write on the mask.

A small arming state machine suppresses detection right after reset until the pin history holds two real samples, so a pin that is already high when reset is released is not reported as an edge. Its states are FILL (the history holds reset values), ARM (one real sample is held) and RUN (detection enabled). The transitions are FILL to ARM and ARM to RUN, each taken unconditionally on the next clock, and RUN to RUN. Reset returns the machine to FILL. The bank-lock logic outside this block gates `bus_wr`, so every write that arrives here is treated as permitted.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every status bit reads 0, every mask bit reads 1 and `irq` is 0.
- R2: With trigger code 01, a 0-to-1 change on a pin sets its status bit. The bit reads 1 after the second rising clock edge that follows the input change. A 1-to-0 change sets nothing.
- R3: With trigger code 10, a 1-to-0 change on a pin sets its status bit, and a 0-to-1 change sets nothing.
- R4: With trigger code 11, both a rising and a falling change set the pin's status bit.
- R5: With trigger code 00, the pin never sets its status bit. The trigger field of pin i is `trig_cfg[2*i+1:2*i]`.
- R6: No edge is recorded during the first two clock cycles after reset is released. Pins held high through reset therefore set nothing.
- R7: A write to byte offset 0x080 + 4*BANK_ID clears each status bit whose data bit is 1 and leaves the status bits whose data bit is 0 unchanged. Status bits change only through this write or through a detected edge.
- R8: If an edge on a pin is detected in the same cycle that a status write clears that pin's bit, the bit remains 1.
- R9: A write to offset 0x0A0 + 4*BANK_ID sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R10: A write to offset 0x0C0 + 4*BANK_ID clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R11: `irq` is 1 exactly when some pin has both its status bit set and its mask bit clear. Status bits latch whether or not the pin is masked.
- R12: A write to any other offset, including the register offsets of another bank, changes neither status nor mask.
- R13: `bus_rdata` shows the status register when `bus_addr` is the status offset and the mask register when `bus_addr` is the mask-set or mask-clear offset. At every other offset it shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronised pin levels |
| trig_cfg | input | 64 | Per-pin trigger code, 2 bits per pin, pin i at [2i+1:2i] |
| bus_wr | input | 1 | Register write strobe, already gated by the bank lock |
| bus_addr | input | 12 | Byte offset used for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Bank interrupt, OR of pending and unmasked bits |

## Verification
The hardest case to reach from the ports is an edge detected in the same cycle that a status write clears the same bit. It requires the pin change and the write strobe to be placed exactly one clock apart, so that the clear and the latch land on the same clock edge. The stimulus changes the pin, waits one clock, then issues a write that clears both that bit and a second bit that was already pending. The already-pending bit must drop while the newly detected bit stays set. A second hard case is the reset window: the pins are held high with both-edge triggering through reset and released, and the status is checked to confirm that nothing was recorded.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } arm_state_e;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_e;

    localparam int unsigned STAT_BASE   = 32'h080;
    localparam int unsigned MSET_BASE   = 32'h0A0;
    localparam int unsigned MCLR_BASE   = 32'h0C0;
    localparam int unsigned BANK_STRIDE = 4;

endpackage

// File: rtl/gpio_irq_arm_fsm.sv
module gpio_irq_arm_fsm
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output logic       armed,
    output arm_state_e state_o
);

    arm_state_e state_q;
    arm_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_FILL: state_n = ST_ARM;
            ST_ARM:  state_n = ST_RUN;
            ST_RUN:  state_n = ST_RUN;
            default: state_n = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            ST_FILL: armed = 1'b0;
            ST_ARM:  armed = 1'b0;
            ST_RUN:  armed = 1'b1;
            default: armed = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           armed,
    input  logic [N-1:0]   pin_in,
    input  logic [2*N-1:0] trig_cfg,
    output logic [N-1:0]   edge_hit
);

    logic [N-1:0] pin_q;
    logic [N-1:0] pin_qq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q  <= '0;
            pin_qq <= '0;
        end else begin
            pin_q  <= pin_in;
            pin_qq <= pin_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic  rise;
        logic  fall;
        logic  hit;
        trig_e mode;

        assign mode = trig_e'(trig_cfg[2*i +: 2]);
        assign rise = pin_q[i] & ~pin_qq[i];
        assign fall = ~pin_q[i] & pin_qq[i];

        always_comb begin
            hit = 1'b0;
            unique case (mode)
                TRIG_OFF:  hit = 1'b0;
                TRIG_RISE: hit = rise;
                TRIG_FALL: hit = fall;
                TRIG_BOTH: hit = rise | fall;
            endcase
        end

        assign edge_hit[i] = armed & hit;
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N       = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      edge_hit,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      status_q,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      bus_rdata
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_BASE + BANK_STRIDE * BANK_ID);
    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(MSET_BASE + BANK_STRIDE * BANK_ID);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(MCLR_BASE + BANK_STRIDE * BANK_ID);

    logic         hit_stat;
    logic         hit_mset;
    logic         hit_mclr;
    logic [N-1:0] stat_clr;
    logic [N-1:0] mask_set;
    logic [N-1:0] mask_clr;

    assign hit_stat = (bus_addr == A_STAT);
    assign hit_mset = (bus_addr == A_MSET);
    assign hit_mclr = (bus_addr == A_MCLR);

    assign stat_clr = (bus_wr && hit_stat) ? bus_wdata : '0;
    assign mask_set = (bus_wr && hit_mset) ? bus_wdata : '0;
    assign mask_clr = (bus_wr && hit_mclr) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            status_q <= (status_q & ~stat_clr) | edge_hit;
            mask_q   <= (mask_q | mask_set) & ~mask_clr;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_stat) begin
            bus_rdata = status_q;
        end else if (hit_mset || hit_mclr) begin
            bus_rdata = mask_q;
        end
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N       = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pin_in,
    input  logic [2*N-1:0]    trig_cfg,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic              irq
);

    logic         armed;
    arm_state_e   arm_state;
    logic [N-1:0] edge_hit;
    logic [N-1:0] status_q;
    logic [N-1:0] mask_q;

    gpio_irq_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .state_o (arm_state)
    );

    gpio_edge_detect #(.N(N)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .pin_in   (pin_in),
        .trig_cfg (trig_cfg),
        .edge_hit (edge_hit)
    );

    gpio_irq_regs #(.N(N), .ADDR_W(ADDR_W), .BANK_ID(BANK_ID)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_hit  (edge_hit),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .bus_rdata (bus_rdata)
    );

    assign irq = |(status_q & ~mask_q);

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N       = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned BANK_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      status_q,
    input logic [N-1:0]      mask_q,
    input logic [N-1:0]      edge_hit,
    input arm_state_e        arm_state
);

    localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'(STAT_BASE + BANK_STRIDE * BANK_ID);
    localparam logic [ADDR_W-1:0] C_MSET = ADDR_W'(MSET_BASE + BANK_STRIDE * BANK_ID);
    localparam logic [ADDR_W-1:0] C_MCLR = ADDR_W'(MCLR_BASE + BANK_STRIDE * BANK_ID);

    logic wr_stat;
    logic wr_mset;
    logic wr_mclr;

    assign wr_stat = bus_wr && (bus_addr == C_STAT);
    assign wr_mset = bus_wr && (bus_addr == C_MSET);
    assign wr_mclr = bus_wr && (bus_addr == C_MCLR);

    p_quiet_until_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_state != ST_RUN) |-> (status_q == '0));

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stat) |-> ((status_q & $past(status_q)) == $past(status_q)));

    p_edge_wins_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stat) |-> ((status_q & $past(edge_hit)) == $past(edge_hit)));

    p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_mset) |-> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_mask_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_mclr) |-> ((mask_q & $past(bus_wdata)) == '0));

    p_mask_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_mset) && !$past(wr_mclr) |-> $stable(mask_q));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N(N), .ADDR_W(ADDR_W), .BANK_ID(BANK_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .edge_hit  (edge_hit),
    .arm_state (arm_state)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;

    localparam logic [11:0] A_STAT = 12'h080;
    localparam logic [11:0] A_MSET = 12'h0A0;
    localparam logic [11:0] A_MCLR = 12'h0C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [63:0] trig_cfg = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_irq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .trig_cfg  (trig_cfg),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        step(1);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic read_reg(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [63:0] all_trig(input logic [1:0] code);
        return {32{code}};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        pin_in   = '1;
        trig_cfg = all_trig(2'b11);
        rst_n    = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(5);
        read_reg(A_STAT, v);
        check("R6 no edge from pins high at reset", v, 32'h0);
        read_reg(A_MSET, v);
        check("R1 mask after reset", v, 32'hFFFF_FFFF);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        trig_cfg = all_trig(2'b00);
        pin_in   = '0;
        step(3);
        read_reg(A_STAT, v);
        check("R5 trigger off ignores falling pins", v, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        trig_cfg  = all_trig(2'b01);
        pin_in[3] = 1'b1;
        step(1);
        read_reg(A_STAT, v);
        check("R2 not yet set after one edge", v, 32'h0);
        step(1);
        read_reg(A_STAT, v);
        check("R2 rising sets bit", v, 32'h0000_0008);
        check("R11 masked pending keeps irq low", {31'b0, irq}, 32'h0);
        pin_in[3] = 1'b0;
        step(3);
        read_reg(A_STAT, v);
        check("R2 falling ignored in rise mode", v, 32'h0000_0008);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        read_reg(A_STAT, v);
        check("R7 write one clears", v, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        trig_cfg  = all_trig(2'b10);
        pin_in[7] = 1'b1;
        step(3);
        read_reg(A_STAT, v);
        check("R3 rising ignored in fall mode", v, 32'h0);
        pin_in[7] = 1'b0;
        step(2);
        read_reg(A_STAT, v);
        check("R3 falling sets bit", v, 32'h0000_0080);
        bus_write(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_both();
        logic [31:0] v;
        trig_cfg   = all_trig(2'b11);
        pin_in[12] = 1'b1;
        step(2);
        read_reg(A_STAT, v);
        check("R4 both mode rising", v, 32'h0000_1000);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        pin_in[12] = 1'b0;
        step(2);
        read_reg(A_STAT, v);
        check("R4 both mode falling", v, 32'h0000_1000);
        bus_write(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_off();
        logic [31:0] v;
        trig_cfg        = all_trig(2'b01);
        trig_cfg[41:40] = 2'b00;
        pin_in[20] = 1'b1;
        pin_in[21] = 1'b1;
        step(2);
        pin_in[20] = 1'b0;
        step(2);
        read_reg(A_STAT, v);
        check("R5 trigger off pin stays clear", v, 32'h0020_0000);
        pin_in[21] = 1'b0;
        bus_write(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        trig_cfg = all_trig(2'b01);
        pin_in[1] = 1'b1;
        pin_in[5] = 1'b1;
        pin_in[9] = 1'b1;
        step(2);
        read_reg(A_STAT, v);
        check("R2 three pins pending", v, 32'h0000_0222);
        bus_write(A_STAT, 32'h0000_0020);
        read_reg(A_STAT, v);
        check("R7 only written bit clears", v, 32'h0000_0202);
        bus_write(A_STAT, 32'h0);
        read_reg(A_STAT, v);
        check("R7 zero write leaves status", v, 32'h0000_0202);
        pin_in = '0;
        bus_write(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        trig_cfg   = all_trig(2'b01);
        pin_in[30] = 1'b1;
        step(2);
        pin_in[31] = 1'b1;
        step(1);
        bus_write(A_STAT, 32'hC000_0000);
        read_reg(A_STAT, v);
        check("R8 edge with clear stays pending", v, 32'h8000_0000);
        pin_in = '0;
        step(2);
        bus_write(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        trig_cfg  = all_trig(2'b01);
        pin_in[2] = 1'b1;
        step(2);
        check("R11 masked irq low", {31'b0, irq}, 32'h0);
        bus_write(A_MCLR, 32'h0000_0004);
        check("R10 unmask raises irq", {31'b0, irq}, 32'h1);
        read_reg(A_MCLR, v);
        check("R13 mask via clear offset", v, 32'hFFFF_FFFB);
        bus_write(A_MSET, 32'h0000_0004);
        check("R9 mask set lowers irq", {31'b0, irq}, 32'h0);
        read_reg(A_MSET, v);
        check("R9 mask all set", v, 32'hFFFF_FFFF);
        bus_write(A_MCLR, 32'h0000_0004);
        bus_write(A_STAT, 32'h0000_0004);
        check("R11 cleared status lowers irq", {31'b0, irq}, 32'h0);
        bus_write(A_MSET, 32'hFFFF_FFFF);
        pin_in = '0;
        step(2);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        trig_cfg   = all_trig(2'b01);
        pin_in[15] = 1'b1;
        step(2);
        bus_write(12'h084, 32'hFFFF_FFFF);
        bus_write(12'h0C4, 32'hFFFF_FFFF);
        bus_write(12'h000, 32'hFFFF_FFFF);
        read_reg(A_STAT, v);
        check("R12 foreign writes keep status", v, 32'h0000_8000);
        read_reg(A_MSET, v);
        check("R12 foreign writes keep mask", v, 32'hFFFF_FFFF);
        read_reg(12'h084, v);
        check("R13 other offset reads zero", v, 32'h0);
        pin_in = '0;
        bus_write(A_STAT, 32'hFFFF_FFFF);
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_off();
        t_w1c();
        t_same_cycle();
        t_mask();
        t_ignore();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule